// File: doc/BRIEF.md
# Seven-Tap Halfband Decimator with One Shared Multiplier

This block filters a stream of signed samples with a fixed seven-tap halfband low-pass response and keeps every second result, which halves the sample rate. It is meant for the fast end of a receive decimation chain, directly after a comb-integrator stage. A design uses one copy for the in-phase path and one for the quadrature path.

The response has a centre tap of one half, two zero taps and two mirrored pairs of nonzero taps. Each mirrored pair of samples is added before the multiply, and the centre tap is a shift, so each output needs two products. Successive outputs are at least two input strobes apart, so one multiplier is enough. On the first cycle it forms the outer-pair product and on the next cycle the inner-pair product. A sum of full width collects both products, and the result is rounded and saturated to the sample width.

When filtering is switched off, every sample goes straight to the output with its strobe. The block still records these samples in its delay line.

Top module: `hb7_decim`

## Requirements
- R1: After a synchronous reset, `dec_vld_o` is 0 and `dec_o` is 0, and every delay-line entry holds zero, so the first outputs treat samples before reset as zero.
- R2: With `filt_en_i` high, one output is produced for every second accepted input strobe. These are the 2nd, 4th, 6th and so on, counted from reset or from the cycle `filt_en_i` went high. The count restarts whenever `filt_en_i` is low.
- R3: For an output triggered by sample x[n], the value is y = (C_OUT*(x[n]+x[n-6]) + C_IN*(x[n-2]+x[n-4]) + 2^(FRAC-1)*x[n-3]) / 2^FRAC, where x[n-k] is the k-th accepted sample before x[n]. Taps k=1 and k=5 are zero. The defaults are C_OUT=-1, C_IN=9 and FRAC=5.
- R4: The division by 2^FRAC rounds half up: 2^(FRAC-1) is added and then the floor is taken.
- R5: Results outside the signed W-bit range are clamped to 2^(W-1)-1 or -2^(W-1).
- R6: In filter mode, the output strobe is high exactly three clock edges after the edge that accepted the triggering sample, for one cycle.
- R7: Input strobes on consecutive cycles are all accepted, and no output is lost or corrupted, whether strobes come back to back or with gaps.
- R8: Every accepted sample enters the delay line in both modes. The first filtered outputs after re-enabling therefore use the samples that were passed through in bypass.
- R9: With `filt_en_i` low, each accepted sample appears on `dec_o` with `dec_vld_o` high one edge later, unchanged. `filt_en_i` changes only when no filtered output is pending.
- R10: While `dec_vld_o` is low, `dec_o` holds its last value.
- R11: No output strobe appears without a corresponding input strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| filt_en_i | input | 1 | 1 = filter and decimate, 0 = pass through |
| smp_vld_i | input | 1 | Input sample strobe |
| smp_i | input | W | Signed input sample |
| dec_vld_o | output | 1 | Output sample strobe |
| dec_o | output | W | Signed output sample |

## Verification
Two events can fall on the same clock edge when input strobes come on consecutive cycles. At that edge, the inner-pair product of one output completes and is written to the output, and the pre-added pairs of the next output are latched. That edge is followed at once by the outer-pair product of the new output. Long runs of back-to-back strobes provoke this overlap, and so do streams from a pseudo-random generator with irregular gaps. The bench judges each output against a model that does the arithmetic of the filter equation in integers, and it checks the cycle in which each output arrives.

// File: rtl/hb7_decim.sv
module hb7_decim #(
  parameter int W     = 16,
  parameter int CW    = 8,
  parameter int FRAC  = 5,
  parameter int C_OUT = -1,
  parameter int C_IN  = 9
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                filt_en_i,
  input  logic                smp_vld_i,
  input  logic signed [W-1:0] smp_i,
  output logic                dec_vld_o,
  output logic signed [W-1:0] dec_o
);

  localparam int PW = W + 1;
  localparam int MW = PW + CW;
  localparam int AW = W + CW + 4;
  localparam logic signed [CW-1:0] KO   = CW'(C_OUT);
  localparam logic signed [CW-1:0] KI   = CW'(C_IN);
  localparam logic signed [AW-1:0] HALF = AW'(1 << (FRAC - 1));
  localparam logic signed [AW-1:0] YMAX = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [AW-1:0] YMIN = {{(AW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [W-1:0]  win [6];
  logic                 phase;
  logic [1:0]           step;
  logic signed [PW-1:0] pre_o, pre_i;
  logic signed [W-1:0]  ctr;
  logic signed [AW-1:0] acc;

  wire take = filt_en_i && smp_vld_i && phase;

  wire signed [PW-1:0] m_op   = (step == 2'd1) ? pre_o : pre_i;
  wire signed [CW-1:0] m_cf   = (step == 2'd1) ? KO : KI;
  wire signed [MW-1:0] prod   = m_op * m_cf;
  wire signed [AW-1:0] prod_x = {{(AW-MW){prod[MW-1]}}, prod};
  wire signed [AW-1:0] ctr_e  = {{(AW-W){ctr[W-1]}}, ctr};
  wire signed [AW-1:0] ctr_x  = ctr_e <<< (FRAC - 1);
  wire signed [AW-1:0] sum    = acc + prod_x;
  wire signed [AW-1:0] rnd    = sum + HALF;
  wire signed [AW-1:0] shr    = rnd >>> FRAC;
  wire signed [W-1:0]  sat    = (shr > YMAX) ? YMAX[W-1:0] :
                                (shr < YMIN) ? YMIN[W-1:0] : shr[W-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int k = 0; k < 6; k++) win[k] <= '0;
    end else if (smp_vld_i) begin
      win[0] <= smp_i;
      for (int k = 1; k < 6; k++) win[k] <= win[k-1];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)           phase <= 1'b0;
    else if (!filt_en_i) phase <= 1'b0;
    else if (smp_vld_i)  phase <= ~phase;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pre_o <= '0;
      pre_i <= '0;
      ctr   <= '0;
    end else if (take) begin
      pre_o <= {smp_i[W-1], smp_i} + {win[5][W-1], win[5]};
      pre_i <= {win[1][W-1], win[1]} + {win[3][W-1], win[3]};
      ctr   <= win[2];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)              step <= 2'd0;
    else if (take)          step <= 2'd1;
    else if (step == 2'd1)  step <= 2'd2;
    else                    step <= 2'd0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)             acc <= '0;
    else if (step == 2'd1) acc <= ctr_x + prod_x;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dec_vld_o <= 1'b0;
      dec_o     <= '0;
    end else begin
      dec_vld_o <= 1'b0;
      if (!filt_en_i) begin
        if (smp_vld_i) begin
          dec_o     <= smp_i;
          dec_vld_o <= 1'b1;
        end
      end else if (step == 2'd2) begin
        dec_o     <= sat;
        dec_vld_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hb7_decim_chk.sv
module hb7_decim_chk #(
  parameter int W = 16
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                filt_en_i,
  input logic                smp_vld_i,
  input logic signed [W-1:0] smp_i,
  input logic                dec_vld_o,
  input logic signed [W-1:0] dec_o
);

  // R9
  bypass_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!filt_en_i && smp_vld_i) |=> (dec_vld_o && dec_o == $past(smp_i)));

  // R2
  decim_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (dec_vld_o && filt_en_i) |=> (!dec_vld_o || !filt_en_i));

  // R6
  latency_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (dec_vld_o && $past(filt_en_i) && $past(filt_en_i, 2) && $past(filt_en_i, 3))
      |-> $past(smp_vld_i, 3));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !dec_vld_o |-> $stable(dec_o));

endmodule

bind hb7_decim hb7_decim_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .filt_en_i(filt_en_i), .smp_vld_i(smp_vld_i),
  .smp_i(smp_i), .dec_vld_o(dec_vld_o), .dec_o(dec_o)
);

// File: tb/sim_hb7_decim.sv
module sim_hb7_decim;
  localparam int W = 16;
  localparam int YMAX = 32767;
  localparam int YMIN = -32768;

  logic                clk_i = 1'b0;
  logic                rst_i = 1'b1;
  logic                filt_en_i = 1'b0;
  logic                smp_vld_i = 1'b0;
  logic signed [W-1:0] smp_i = '0;
  wire                 dec_vld_o;
  wire signed [W-1:0]  dec_o;

  always #4 clk_i = ~clk_i;

  hb7_decim u0 (
    .clk_i(clk_i), .rst_i(rst_i), .filt_en_i(filt_en_i), .smp_vld_i(smp_vld_i),
    .smp_i(smp_i), .dec_vld_o(dec_vld_o), .dec_o(dec_o)
  );

  int checks = 0, fails = 0, cyc = 0, nout = 0;
  int hist [7];
  bit ph = 1'b0, mon = 1'b0, done = 1'b0;
  int ev [$];
  int ec [$];
  string et [$];
  string ftag = "R3";
  int last = 0, e_v, e_c;
  string e_t;
  bit [15:0] lf = 16'hACE1;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_y();
    int a;
    a = -1 * (hist[0] + hist[6]) + 9 * (hist[2] + hist[4]) + 16 * hist[3];
    a = (a + 16) >>> 5;
    if (a > YMAX) a = YMAX;
    if (a < YMIN) a = YMIN;
    return a;
  endfunction

  task automatic put(bit v, int x);
    smp_vld_i = v;
    smp_i = x[W-1:0];
    if (v) begin
      for (int k = 6; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      if (filt_en_i) begin
        if (ph) begin
          ev.push_back(ref_y()); ec.push_back(cyc + 3); et.push_back(ftag);
        end
        ph = ~ph;
      end else begin
        ev.push_back(x); ec.push_back(cyc + 1); et.push_back("R9");
        ph = 1'b0;
      end
    end
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) put(1'b0, 0);
  endtask

  task automatic set_en(bit e);
    idle(4);
    filt_en_i = e;
    ph = 1'b0;
  endtask

  task automatic lf_step();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  always @(negedge clk_i) begin
    if (mon) begin
      if (dec_vld_o) begin
        nout++;
        if (ev.size() == 0) chk(1'b0, "R11", int'(dec_o), 0);
        else begin
          e_v = ev.pop_front(); e_c = ec.pop_front(); e_t = et.pop_front();
          chk(int'(dec_o) == e_v, e_t, int'(dec_o), e_v);
          chk(cyc == e_c, "R6", cyc, e_c);
        end
        last = int'(dec_o);
      end else begin
        chk(int'(dec_o) == last, "R10", int'(dec_o), last);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R7 act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    int amps [7] = '{1, -1, 1000, -1000, 32767, -32768, 12345};
    int pat [7];
    int n0;
    for (int k = 0; k < 7; k++) hist[k] = 0;
    repeat (3) @(negedge clk_i);
    rst_i = 1'b0;
    @(negedge clk_i);
    chk(dec_vld_o == 1'b0, "R1", int'(dec_vld_o), 0);
    chk(int'(dec_o) == 0, "R1", int'(dec_o), 0);
    mon = 1'b1;
    filt_en_i = 1'b1;

    ftag = "R1";
    put(1'b1, 5000); put(1'b1, -7000); put(1'b1, 3000); put(1'b1, 100);

    ftag = "R3";
    foreach (amps[a])
      for (int pos = 0; pos < 4; pos++)
        for (int i = 0; i < 10; i++) put(1'b1, (i == pos) ? amps[a] : 0);

    ftag = "R4";
    for (int v = -40; v <= 40; v++) put(1'b1, v);
    for (int v = -40; v <= 40; v++) put(1'b1, 3 * v + 1);

    ftag = "R5";
    pat = '{YMIN, 0, YMAX, YMAX, YMAX, 0, YMIN};
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 7; k++) put(1'b1, pat[k]);
    pat = '{YMAX, 0, YMIN, YMIN, YMIN, 0, YMAX};
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 7; k++) put(1'b1, pat[k]);

    idle(5);
    n0 = nout;
    ftag = "R2";
    for (int i = 0; i < 10; i++) put(1'b1, i * 111 - 400);
    idle(5);
    chk(nout - n0 == 5, "R2", nout - n0, 5);

    ftag = "R7";
    for (int i = 0; i < 300; i++) begin
      lf_step();
      if (lf[0] && lf[3]) put(1'b0, 0);
      put(1'b1, int'($signed(lf)));
    end

    set_en(1'b0);
    for (int i = 0; i < 40; i++) begin
      lf_step();
      if (lf[1]) put(1'b0, 0);
      put(1'b1, int'($signed(lf)));
    end
    set_en(1'b1);
    ftag = "R8";
    for (int i = 0; i < 12; i++) put(1'b1, (i % 3) * 2000 - 1500);

    idle(20);
    chk(ev.size() == 0, "R7", ev.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule